// File: doc/BRIEF.md
# Teletext Broadcast Packet Byte Extractor

This block sits behind a teletext slicer and byte framer. It receives row bytes that are already aligned, one per cycle. Each byte comes with its position inside the row and a code that says what kind of row it belongs to. Two mode inputs choose which row kind and which byte window are captured. In the protected-packet mode, every captured byte goes through a Hamming 8/4 check and a single-bit error is repaired before the byte is kept. In the raw-packet mode and the header-clock mode, the bytes are kept exactly as they arrive.

Captured bytes first collect in a shadow buffer. At the end-of-row strobe the whole shadow buffer is copied to the transfer bank in one cycle, and an active-low data-available flag drops. The copy only happens if the row delivered at least one wanted byte, no protected byte in it was beyond repair, and the host is not busy with the bank. The host reads the bank one byte at a time through an index port. When the host starts a read, the flag goes high again.

Top module: `ttxByteExtract`

## Requirements
- R1: After reset `dataAvailN` is 1 and every bank entry reads 0.
- R2: With `modeFmt2`=1, the bytes at positions 13..25 of a row with `rowType`=2 land in bank entries 0..12 (position minus 13). After the `lineEnd` cycle that commits them, `dataAvailN` reads 0.
- R3: A protected byte is coded as bit0=P1, bit1=D1, bit2=P2, bit3=D2, bit4=P3, bit5=D3, bit6=P4, bit7=D4. The groups {b0,b1,b5,b7}, {b1,b2,b3,b7} and {b1,b3,b4,b5} each have odd parity, and so do all eight bits together. A byte with one flipped bit is stored in its repaired form.
- R4: A protected row that contains a byte with two flipped bits is thrown away as a whole. The bank and `dataAvailN` keep their values.
- R5: With `modeFmt2`=0 and `modeHeader`=0, the bytes at positions 13..25 of a row with `rowType`=1 are stored bit for bit, with no parity check.
- R6: With `modeFmt2`=0 and `modeHeader`=1, the bytes at positions 38..45 of a row with `rowType`=3 land in bank entries 0..7.
- R7: Rows whose `rowType` differs from the selected kind have no effect, and so do bytes outside the selected window.
- R8: A `lineEnd` that arrives while `hostBusy`=1 commits nothing. The row is dropped, and the bank and flag stay as they were.
- R9: A `hostReadStart` pulse that does not coincide with a commit sets `dataAvailN` to 1 on the next cycle.
- R10: The bank does not change while row bytes are still arriving. It changes only in the cycle that follows a committing `lineEnd`.
- R11: A `lineEnd` after a row that delivered no wanted byte changes neither the bank nor the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| byteValid | input | 1 | A row byte is present this cycle |
| byteData | input | 8 | Row byte value |
| bytePos | input | 6 | Position of the byte in its row |
| rowType | input | 2 | Row kind: 0 other, 1 raw packet, 2 protected packet, 3 page header |
| lineEnd | input | 1 | End-of-row strobe; requests the commit |
| modeFmt2 | input | 1 | 1 selects the protected packet |
| modeHeader | input | 1 | With modeFmt2=0, 1 selects header clock bytes instead of the raw packet |
| hostBusy | input | 1 | Host is accessing the bank |
| hostReadStart | input | 1 | Host begins a read of the bank |
| rdIdx | input | 4 | Bank entry to read |
| rdData | output | 8 | Bank entry value (combinational from the bank) |
| dataAvailN | output | 1 | Active-low data-available flag |

## Verification
Each byte is written to the shadow buffer on the clock edge at which it is presented. A committing `lineEnd` updates the bank and `dataAvailN` on its own edge, so both are valid one cycle after the strobe. A `hostReadStart` likewise shows on `dataAvailN` one edge later. The bench drives inputs on falling edges and samples on the falling edge that follows the edge where a result is due. `rdData` is combinational, so the bench reads it a short delay after changing `rdIdx`. Rows that are thrown away are checked by reading the bank back in full and by watching the flag one cycle after their `lineEnd`.

// File: rtl/ttxExtractPkg.sv
package ttxExtractPkg;
  localparam int POS_W      = 6;
  localparam int FMT_FIRST  = 13;
  localparam int FMT_LAST   = 25;
  localparam int HDR_FIRST  = 38;
  localparam int HDR_LAST   = 45;
  localparam int BANK_DEPTH = FMT_LAST - FMT_FIRST + 1;
  localparam int IDX_W      = $clog2(BANK_DEPTH);

  typedef enum logic [1:0] {
    ROW_OTHER  = 2'd0,
    ROW_FMT1   = 2'd1,
    ROW_FMT2   = 2'd2,
    ROW_HEADER = 2'd3
  } rowKind_e;

  typedef struct packed {
    logic             shadowWr;
    logic             useHamming;
    logic [IDX_W-1:0] shadowIdx;
    logic             commit;
  } ctrlStrobe_t;
endpackage

// File: rtl/ttxHamming84.sv
module ttxHamming84 (
  input  logic [7:0] codeIn,
  output logic [7:0] codeFix,
  output logic       uncorrectable
);
  logic failA, failB, failC, failAll;
  logic [2:0] syndrome;

  always_comb begin
    failA    = ~(codeIn[0] ^ codeIn[1] ^ codeIn[5] ^ codeIn[7]);
    failB    = ~(codeIn[1] ^ codeIn[2] ^ codeIn[3] ^ codeIn[7]);
    failC    = ~(codeIn[1] ^ codeIn[3] ^ codeIn[4] ^ codeIn[5]);
    failAll  = ~(^codeIn);
    syndrome = {failC, failB, failA};
    codeFix  = codeIn;
    uncorrectable = 1'b0;
    if (failAll) begin
      case (syndrome)
        3'd0: codeFix[6] = ~codeIn[6];
        3'd1: codeFix[0] = ~codeIn[0];
        3'd2: codeFix[2] = ~codeIn[2];
        3'd3: codeFix[7] = ~codeIn[7];
        3'd4: codeFix[4] = ~codeIn[4];
        3'd5: codeFix[5] = ~codeIn[5];
        3'd6: codeFix[3] = ~codeIn[3];
        default: codeFix[1] = ~codeIn[1];
      endcase
    end else if (syndrome != 3'd0) begin
      uncorrectable = 1'b1;
    end
  end

  // R3
  always_comb begin
    if (!uncorrectable)
      hamming_fix_chk: assert ((^codeFix) && (codeFix[0] ^ codeFix[1] ^ codeFix[5] ^ codeFix[7])
                               && (codeFix[1] ^ codeFix[2] ^ codeFix[3] ^ codeFix[7])
                               && (codeFix[1] ^ codeFix[3] ^ codeFix[4] ^ codeFix[5]));
  end
endmodule

// File: rtl/ttxExtractCtrl.sv
module ttxExtractCtrl
  import ttxExtractPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              byteValid,
  input  logic [POS_W-1:0]  bytePos,
  input  logic [1:0]        rowType,
  input  logic              lineEnd,
  input  logic              modeFmt2,
  input  logic              modeHeader,
  input  logic              hostBusy,
  input  logic              hostReadStart,
  input  logic              hamBad,
  output ctrlStrobe_t       strobes,
  output logic              dataAvailN
);
  rowKind_e         selKind;
  logic [POS_W-1:0] winFirst, winLast;
  logic             inWin;
  logic             lineHit, lineBad;

  always_comb begin
    if (modeFmt2)        selKind = ROW_FMT2;
    else if (modeHeader) selKind = ROW_HEADER;
    else                 selKind = ROW_FMT1;
    if (selKind == ROW_HEADER) begin
      winFirst = POS_W'(HDR_FIRST);
      winLast  = POS_W'(HDR_LAST);
    end else begin
      winFirst = POS_W'(FMT_FIRST);
      winLast  = POS_W'(FMT_LAST);
    end
    inWin = byteValid && !lineEnd && (rowType == selKind)
            && (bytePos >= winFirst) && (bytePos <= winLast);
    strobes.shadowWr   = inWin;
    strobes.useHamming = modeFmt2;
    strobes.shadowIdx  = IDX_W'(bytePos - winFirst);
    strobes.commit     = lineEnd && lineHit && !lineBad && !hostBusy;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lineHit    <= 1'b0;
      lineBad    <= 1'b0;
      dataAvailN <= 1'b1;
    end else begin
      if (lineEnd) begin
        lineHit <= 1'b0;
        lineBad <= 1'b0;
      end else if (inWin) begin
        lineHit <= 1'b1;
        if (modeFmt2 && hamBad) lineBad <= 1'b1;
      end
      if (strobes.commit)     dataAvailN <= 1'b0;
      else if (hostReadStart) dataAvailN <= 1'b1;
    end
  end

  // R2
  avail_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(dataAvailN) |-> $past(lineEnd));
  // R9
  read_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    hostReadStart && !lineEnd |=> dataAvailN);
  // R8
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    lineEnd && hostBusy && !hostReadStart |=> $stable(dataAvailN));
endmodule

// File: rtl/ttxExtractData.sv
module ttxExtractData
  import ttxExtractPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [7:0]       byteData,
  input  ctrlStrobe_t      strobes,
  input  logic [IDX_W-1:0] rdIdx,
  output logic [7:0]       rdData,
  output logic             hamBad
);
  logic [BANK_DEPTH-1:0][7:0] shadow;
  logic [BANK_DEPTH-1:0][7:0] bank;
  logic [7:0] fixedByte;
  logic [7:0] storeByte;

  ttxHamming84 ham_i (
    .codeIn        (byteData),
    .codeFix       (fixedByte),
    .uncorrectable (hamBad)
  );

  assign storeByte = strobes.useHamming ? fixedByte : byteData;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shadow <= '0;
      bank   <= '0;
    end else begin
      if (strobes.shadowWr && (int'(strobes.shadowIdx) < BANK_DEPTH))
        shadow[strobes.shadowIdx] <= storeByte;
      if (strobes.commit)
        bank <= shadow;
    end
  end

  always_comb begin
    rdData = 8'h00;
    if (int'(rdIdx) < BANK_DEPTH) rdData = bank[rdIdx];
  end

  // R10
  bank_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.commit |=> $stable(bank));
endmodule

// File: rtl/ttxByteExtract.sv
module ttxByteExtract
  import ttxExtractPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             byteValid,
  input  logic [7:0]       byteData,
  input  logic [POS_W-1:0] bytePos,
  input  logic [1:0]       rowType,
  input  logic             lineEnd,
  input  logic             modeFmt2,
  input  logic             modeHeader,
  input  logic             hostBusy,
  input  logic             hostReadStart,
  input  logic [IDX_W-1:0] rdIdx,
  output logic [7:0]       rdData,
  output logic             dataAvailN
);
  ctrlStrobe_t strobes;
  logic        hamBad;

  ttxExtractCtrl ctrl_i (
    .clk, .rstN, .byteValid, .bytePos, .rowType, .lineEnd,
    .modeFmt2, .modeHeader, .hostBusy, .hostReadStart,
    .hamBad, .strobes, .dataAvailN
  );

  ttxExtractData data_i (
    .clk, .rstN, .byteData, .strobes, .rdIdx, .rdData, .hamBad
  );
endmodule

// File: tb/ttxByteExtract_tb_top.sv
module ttxByteExtract_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic byteValid = 1'b0;
  logic [7:0] byteData = 8'h00;
  logic [5:0] bytePos = 6'd0;
  logic [1:0] rowType = 2'd0;
  logic lineEnd = 1'b0;
  logic modeFmt2 = 1'b0;
  logic modeHeader = 1'b0;
  logic hostBusy = 1'b0;
  logic hostReadStart = 1'b0;
  logic [3:0] rdIdx = 4'd0;
  logic [7:0] rdData;
  logic dataAvailN;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [7:0] rowBuf [0:63];
  logic [7:0] expBank [0:12];

  always #4 clk = ~clk;

  ttxByteExtract dut_i (.*);

  function automatic logic [7:0] enc(input logic [3:0] n);
    logic d1, d2, d3, d4, p1, p2, p3, p4;
    d1 = n[0]; d2 = n[1]; d3 = n[2]; d4 = n[3];
    p1 = ~(d1 ^ d3 ^ d4);
    p2 = ~(d1 ^ d2 ^ d4);
    p3 = ~(d1 ^ d2 ^ d3);
    p4 = ~(p1 ^ d1 ^ p2 ^ d2 ^ p3 ^ d3 ^ d4);
    return {d4, p4, d3, p3, d2, p2, d1, p1};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic checkBank(input string tag, input int n);
    for (int i = 0; i < n; i++) begin
      rdIdx = 4'(i);
      #1;
      chk(tag, {24'd0, rdData}, {24'd0, expBank[i]});
    end
  endtask

  task automatic sendRow(input logic [1:0] kind, input int lo, input int hi);
    for (int p = lo; p <= hi; p++) begin
      @(negedge clk);
      byteValid = 1'b1; bytePos = 6'(p); byteData = rowBuf[p]; rowType = kind;
    end
    @(negedge clk);
    byteValid = 1'b0;
  endtask

  task automatic endLine();
    @(negedge clk); lineEnd = 1'b1;
    @(negedge clk); lineEnd = 1'b0;
  endtask

  task automatic readStart();
    @(negedge clk); hostReadStart = 1'b1;
    @(negedge clk); hostReadStart = 1'b0;
  endtask

  task automatic testReset();
    for (int i = 0; i < 13; i++) expBank[i] = 8'h00;
    chk("R1 flag after reset", {31'd0, dataAvailN}, 32'd1);
    checkBank("R1 bank after reset", 13);
  endtask

  task automatic testFmt2Clean();
    modeFmt2 = 1'b1;
    for (int p = 0; p < 64; p++) rowBuf[p] = 8'hA5;
    for (int i = 0; i < 13; i++) rowBuf[13 + i] = enc(4'(i + 3));
    sendRow(2'd2, 5, 40);
    checkBank("R10 bank before lineEnd", 13);
    chk("R10 flag before lineEnd", {31'd0, dataAvailN}, 32'd1);
    endLine();
    for (int i = 0; i < 13; i++) expBank[i] = enc(4'(i + 3));
    checkBank("R2 clean protected row", 13);
    chk("R2 flag low after commit", {31'd0, dataAvailN}, 32'd0);
  endtask

  task automatic testReadStart();
    readStart();
    chk("R9 flag high after read start", {31'd0, dataAvailN}, 32'd1);
  endtask

  task automatic testSingleError();
    for (int i = 0; i < 13; i++) begin
      expBank[i] = enc(4'(15 - i));
      rowBuf[13 + i] = expBank[i] ^ (8'h01 << (i % 8));
    end
    sendRow(2'd2, 13, 25);
    endLine();
    checkBank("R3 single-bit repair", 13);
    chk("R3 flag low", {31'd0, dataAvailN}, 32'd0);
  endtask

  task automatic testDoubleError();
    readStart();
    for (int i = 0; i < 13; i++) rowBuf[13 + i] = enc(4'(i));
    rowBuf[18] = rowBuf[18] ^ 8'h03;
    sendRow(2'd2, 13, 25);
    endLine();
    checkBank("R4 bank kept after double error", 13);
    chk("R4 flag kept high", {31'd0, dataAvailN}, 32'd1);
  endtask

  task automatic testWrongType();
    for (int i = 0; i < 13; i++) rowBuf[13 + i] = 8'h5A;
    sendRow(2'd1, 13, 25);
    sendRow(2'd3, 38, 45);
    endLine();
    checkBank("R7 other row kinds ignored", 13);
    chk("R11 flag unchanged on empty line", {31'd0, dataAvailN}, 32'd1);
  endtask

  task automatic testHostBusy();
    for (int i = 0; i < 13; i++) rowBuf[13 + i] = enc(4'(i ^ 5));
    sendRow(2'd2, 13, 25);
    hostBusy = 1'b1;
    endLine();
    hostBusy = 1'b0;
    checkBank("R8 bank kept while host busy", 13);
    chk("R8 flag kept while host busy", {31'd0, dataAvailN}, 32'd1);
  endtask

  task automatic testFmt1Raw();
    modeFmt2 = 1'b0; modeHeader = 1'b0;
    for (int i = 0; i < 13; i++) rowBuf[13 + i] = 8'(i * 37 + 1);
    rowBuf[13] = 8'hFF; rowBuf[14] = 8'h00; rowBuf[25] = 8'h03;
    sendRow(2'd1, 10, 30);
    endLine();
    for (int i = 0; i < 13; i++) expBank[i] = rowBuf[13 + i];
    checkBank("R5 raw packet copied unchanged", 13);
    chk("R5 flag low", {31'd0, dataAvailN}, 32'd0);
  endtask

  task automatic testHeader();
    readStart();
    modeHeader = 1'b1;
    for (int p = 30; p <= 50; p++) rowBuf[p] = 8'(p + 8'h40);
    sendRow(2'd3, 30, 50);
    endLine();
    for (int i = 0; i < 8; i++) expBank[i] = rowBuf[38 + i];
    checkBank("R6 header clock bytes", 8);
    chk("R6 flag low", {31'd0, dataAvailN}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testFmt2Clean();
    testReadStart();
    testSingleError();
    testDoubleError();
    testWrongType();
    testHostBusy();
    testFmt1Raw();
    testHeader();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule